// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a virtual address into a physical address through a small table of segments held in registers. The top bits of the virtual address pick one of the table entries. The remaining bits are an offset inside that segment. Each entry holds a base address, a size limit and a rights code. If the offset fits within the limit and the rights allow the requested access, the block outputs the base plus the offset. Otherwise it raises an error flag and outputs no address.

Software loads single entries through a write port. On a context switch it saves and restores the whole table in one step through a flat context bus. Translation is purely combinational, so a result is valid in the same cycle as its address. Table changes become visible from the next clock edge.

Top module: `seg_xlate_top`

## Requirements
- R1: The segment index is taken from bits [31:28] of the virtual address, and the offset from bits [27:0].
- R2: When both checks pass, `pa_ok` is 1 and `pa` equals the entry base plus the zero-extended offset, modulo 2^32.
- R3: The limit check fails only when the offset is strictly greater than the entry size. An offset equal to the size passes. When the limit check fails, `lim_err` is 1, `pa_ok` is 0 and `pa` is 0.
- R4: The access code on `acc` is 0 for read, 1 for write, 2 for execute and 3 for reserved. The rights code is 0 for none, 1 for read-only, 2 for read/write and 3 for read/execute. Code 0 denies every access, and access code 3 is always denied. A denied access sets `prot_err`, clears `pa_ok` and drives `pa` to 0.
- R5: The limit fault and the rights fault are evaluated independently in the same cycle, so both flags can be 1 together.
- R6: After a synchronous active-low reset, every entry has base 0, size 0 and rights 0. `ctx_out` is all zeros and every access sets `prot_err`.
- R7: A single-entry write through `wr_en`/`wr_idx` changes that entry at the next rising edge. A translation in the same cycle as the write still sees the old contents, and the other entries are unchanged.
- R8: `ctx_out` shows the whole table. Entry i sits at bits [i*62 +: 62], packed as {base[61:30], size[29:2], rights[1:0]}.
- R9: `ctx_load` replaces the whole table from `ctx_in`, in the layout of R8, at the next edge. It overrides a single-entry write issued in the same cycle.
- R10: Translation is combinational: the outputs follow `va`, `acc` and the table within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| va | input | 32 | Virtual address |
| acc | input | 2 | Access type code |
| pa | output | 32 | Physical address, 0 on any fault |
| pa_ok | output | 1 | Translation succeeded |
| lim_err | output | 1 | Offset beyond segment size |
| prot_err | output | 1 | Rights do not permit the access |
| wr_en | input | 1 | Write one table entry |
| wr_idx | input | 4 | Entry to write |
| wr_base | input | 32 | New base |
| wr_size | input | 28 | New size limit |
| wr_prot | input | 2 | New rights code |
| ctx_load | input | 1 | Load the whole table from ctx_in |
| ctx_in | input | 992 | Packed table image to restore |
| ctx_out | output | 992 | Packed image of the current table |

## Verification
Translations cover several cases: offsets well inside a segment, offsets exactly at the size limit, and offsets one step past it. These separate a strict comparison from an inclusive one. Every pairing of access type and rights code that matters is tried, including the reserved access code and the empty rights code. Together they show that each rights level grants exactly its own set of accesses. One segment has a base near the top of the address space, which shows that the sum wraps. Another access breaks both rules at once, which shows the two flags are independent. Table writes and context loads are issued in the same cycle as a translation, and in the same cycle as each other. This shows when new contents become visible and which load wins.

// File: rtl/seg_xlate_pkg.sv
// Package: shared codes for the segment translator.
// Assumes two-bit rights and access codes as listed in the brief.
package seg_xlate_pkg;
    typedef enum logic [1:0] {
        RIGHTS_NONE = 2'd0,
        RIGHTS_RO   = 2'd1,
        RIGHTS_RW   = 2'd2,
        RIGHTS_RX   = 2'd3
    } rights_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    // Decide whether a rights level permits an access kind.
    function automatic logic rights_allow(rights_e r, access_e a);
        logic ok;
        case (r)
            RIGHTS_RO: ok = (a == ACC_READ);
            RIGHTS_RW: ok = (a == ACC_READ) || (a == ACC_WRITE);
            RIGHTS_RX: ok = (a == ACC_READ) || (a == ACC_EXEC);
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/seg_table.sv
// Module: seg_table
// Holds the segment entries in flops. It takes single-entry writes and
// whole-table context loads; a context load has priority. It offers one
// combinational read port and a flat image of the table.
// Assumes: synchronous active-low reset; EW = PA_W + OFF_W + 2.
module seg_table
    import seg_xlate_pkg::*;
#(
    parameter int NSEG  = 16,
    parameter int PA_W  = 32,
    parameter int OFF_W = 28,
    parameter int IDX_W = $clog2(NSEG),
    parameter int EW    = PA_W + OFF_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [OFF_W-1:0]    wr_size,
    input  rights_e             wr_prot,
    input  logic                ctx_load,
    input  logic [NSEG*EW-1:0]  ctx_in,
    output logic [NSEG*EW-1:0]  ctx_out,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [PA_W-1:0]     rd_base,
    output logic [OFF_W-1:0]    rd_size,
    output rights_e             rd_prot
);
    logic [PA_W-1:0]  base_q [NSEG];
    logic [OFF_W-1:0] size_q [NSEG];
    rights_e          prot_q [NSEG];

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        // Update entry i from reset, a context load or a single write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[i] <= '0;
                size_q[i] <= '0;
                prot_q[i] <= RIGHTS_NONE;
            end else if (ctx_load) begin
                base_q[i] <= ctx_in[i*EW + EW - 1 -: PA_W];
                size_q[i] <= ctx_in[i*EW + 2 +: OFF_W];
                prot_q[i] <= rights_e'(ctx_in[i*EW +: 2]);
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                base_q[i] <= wr_base;
                size_q[i] <= wr_size;
                prot_q[i] <= wr_prot;
            end
        end

        // Pack entry i into the flat context image.
        assign ctx_out[i*EW +: EW] = {base_q[i], size_q[i], prot_q[i]};
    end

    // Read port for the translation path.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_size = size_q[rd_idx];
        rd_prot = prot_q[rd_idx];
    end

    // R7
    wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ctx_load) |=> (base_q[$past(wr_idx)] == $past(wr_base)
                                  && size_q[$past(wr_idx)] == $past(wr_size)));
    // R9
    ctx_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_load |=> (ctx_out == $past(ctx_in)));
endmodule

// File: rtl/seg_check.sv
// Module: seg_check
// Combinational limit and rights checks and the address sum for one entry.
// Assumes PA_W >= OFF_W. clk/rst_n serve only the local assertions.
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int OFF_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFF_W-1:0]  off,
    input  access_e           acc,
    input  logic [PA_W-1:0]   base,
    input  logic [OFF_W-1:0]  size,
    input  rights_e           prot,
    output logic [PA_W-1:0]   pa,
    output logic              pa_ok,
    output logic              lim_err,
    output logic              prot_err
);
    localparam int PAD_W = PA_W - OFF_W;

    // Evaluate both faults separately and gate the address on both.
    always_comb begin
        lim_err  = (off > size);
        prot_err = !rights_allow(prot, acc);
        pa_ok    = !lim_err && !prot_err;
        pa       = pa_ok ? (base + {{PAD_W{1'b0}}, off}) : '0;
    end

    // R4
    none_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot == RIGHTS_NONE || acc == ACC_RSVD) |-> (prot_err && !pa_ok));
    // R3
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_ok |-> (pa == '0));
    // R5
    ok_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pa_ok |-> (!lim_err && !prot_err));
endmodule

// File: rtl/seg_xlate_top.sv
// Module: seg_xlate_top
// Segment translator: splits the virtual address and looks up its entry,
// then checks limit and rights and forms the physical address, all in the
// same cycle. Assumes VA_W > SEG_W and PA_W >= VA_W - SEG_W.
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int SEG_W = 4,
    parameter int PA_W  = 32,
    localparam int OFF_W = VA_W - SEG_W,
    localparam int NSEG  = 1 << SEG_W,
    localparam int EW    = PA_W + OFF_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [VA_W-1:0]     va,
    input  logic [1:0]          acc,
    output logic [PA_W-1:0]     pa,
    output logic                pa_ok,
    output logic                lim_err,
    output logic                prot_err,
    input  logic                wr_en,
    input  logic [SEG_W-1:0]    wr_idx,
    input  logic [PA_W-1:0]     wr_base,
    input  logic [OFF_W-1:0]    wr_size,
    input  logic [1:0]          wr_prot,
    input  logic                ctx_load,
    input  logic [NSEG*EW-1:0]  ctx_in,
    output logic [NSEG*EW-1:0]  ctx_out
);
    logic [SEG_W-1:0] seg_idx;
    logic [OFF_W-1:0] seg_off;
    logic [PA_W-1:0]  ent_base;
    logic [OFF_W-1:0] ent_size;
    rights_e          ent_prot;

    // Split the virtual address into index and offset (R1).
    assign seg_idx = va[VA_W-1 -: SEG_W];
    assign seg_off = va[OFF_W-1:0];

    seg_table #(
        .NSEG (NSEG),
        .PA_W (PA_W),
        .OFF_W(OFF_W),
        .IDX_W(SEG_W),
        .EW   (EW)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_base (wr_base),
        .wr_size (wr_size),
        .wr_prot (rights_e'(wr_prot)),
        .ctx_load(ctx_load),
        .ctx_in  (ctx_in),
        .ctx_out (ctx_out),
        .rd_idx  (seg_idx),
        .rd_base (ent_base),
        .rd_size (ent_size),
        .rd_prot (ent_prot)
    );

    // Check and sum on the combinational path (R10).
    seg_check #(
        .PA_W (PA_W),
        .OFF_W(OFF_W)
    ) u_check (
        .clk     (clk),
        .rst_n   (rst_n),
        .off     (seg_off),
        .acc     (access_e'(acc)),
        .base    (ent_base),
        .size    (ent_size),
        .prot    (ent_prot),
        .pa      (pa),
        .pa_ok   (pa_ok),
        .lim_err (lim_err),
        .prot_err(prot_err)
    );

    // R6
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ctx_out == '0));
endmodule

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
    localparam int EW = 62;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [31:0]   va = '0;
    logic [1:0]    acc = '0;
    logic [31:0]   pa;
    logic          pa_ok, lim_err, prot_err;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_idx = '0;
    logic [31:0]   wr_base = '0;
    logic [27:0]   wr_size = '0;
    logic [1:0]    wr_prot = '0;
    logic          ctx_load = 1'b0;
    logic [NS*EW-1:0] ctx_in = '0;
    logic [NS*EW-1:0] ctx_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench's own model of the table.
    logic [31:0] sb [NS];
    logic [27:0] ss [NS];
    logic [1:0]  sp [NS];

    logic [34:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    seg_xlate_top u_dut (
        .clk(clk), .rst_n(rst_n), .va(va), .acc(acc), .pa(pa),
        .pa_ok(pa_ok), .lim_err(lim_err), .prot_err(prot_err),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_base(wr_base),
        .wr_size(wr_size), .wr_prot(wr_prot), .ctx_load(ctx_load),
        .ctx_in(ctx_in), .ctx_out(ctx_out)
    );

    function automatic logic [34:0] model(logic [31:0] a, logic [1:0] k);
        logic [3:0]  s;
        logic [27:0] o;
        logic lim, pe, ok, allow;
        logic [31:0] p;
        s = a[31:28];
        o = a[27:0];
        lim = o > ss[s];
        case (sp[s])
            2'd1: allow = (k == 2'd0);
            2'd2: allow = (k == 2'd0) || (k == 2'd1);
            2'd3: allow = (k == 2'd0) || (k == 2'd2);
            default: allow = 1'b0;
        endcase
        pe = !allow;
        ok = !lim && !pe;
        p = ok ? sb[s] + {4'd0, o} : 32'd0;
        return {p, ok, lim, pe};
    endfunction

    function automatic logic [NS*EW-1:0] image();
        logic [NS*EW-1:0] v;
        for (int i = 0; i < NS; i++) v[i*EW +: EW] = {sb[i], ss[i], sp[i]};
        return v;
    endfunction

    task automatic check(bit cond, string tag, logic [NS*EW-1:0] act, logic [NS*EW-1:0] ex);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, ex);
        end
    endtask

    // Driver: apply one translation and queue its expected result.
    task automatic xl(logic [31:0] a, logic [1:0] k, string tag);
        @(negedge clk);
        va = a;
        acc = k;
        exp_q.push_back(model(a, k));
        tag_q.push_back(tag);
    endtask

    task automatic wr(logic [3:0] i, logic [31:0] b, logic [27:0] s, logic [1:0] p);
        @(negedge clk);
        wr_en = 1; wr_idx = i; wr_base = b; wr_size = s; wr_prot = p;
        sb[i] = b; ss[i] = s; sp[i] = p;
        @(negedge clk);
        wr_en = 0;
    endtask

    // Monitor: compare live outputs against the queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [34:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({pa, pa_ok, lim_err, prot_err} == e, t,
                      {{(NS*EW-35){1'b0}}, pa, pa_ok, lim_err, prot_err},
                      {{(NS*EW-35){1'b0}}, e});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NS*EW-1:0] saved;
        for (int i = 0; i < NS; i++) begin sb[i] = '0; ss[i] = '0; sp[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R6: reset state
        check(ctx_out == '0, "R6 ctx clear", ctx_out, '0);
        xl(32'h0000_0000, 2'd0, "R6 empty table faults");
        xl(32'h5000_0010, 2'd2, "R6 empty table faults exec");

        wr(4'd1, 32'h1000_0000, 28'h0000FFF, 2'd1);
        wr(4'd2, 32'h8000_0000, 28'hFFFFFFF, 2'd2);
        wr(4'd3, 32'h0000_0000, 28'h0000100, 2'd3);
        wr(4'd15, 32'hFFFF_F000, 28'h0002000, 2'd2);

        xl(32'h1000_0010, 2'd0, "R1 R2 read inside seg1");
        xl(32'h1000_0FFF, 2'd0, "R3 offset equal to size");
        xl(32'h1000_1000, 2'd0, "R3 offset past size");
        xl(32'h1000_0020, 2'd1, "R4 write to read-only");
        xl(32'h2ABC_DEF0, 2'd1, "R2 R4 write to read/write");
        xl(32'h2000_0004, 2'd2, "R4 exec on read/write");
        xl(32'h3000_0100, 2'd2, "R4 exec on read/exec at limit");
        xl(32'h3000_0040, 2'd1, "R4 write on read/exec");
        xl(32'h2000_0000, 2'd3, "R4 reserved access");
        xl(32'h1000_1000, 2'd1, "R5 both faults");
        xl(32'hF000_1800, 2'd0, "R2 sum wraps");
        xl(32'h3000_0101, 2'd3, "R5 both faults reserved");

        // R7: write and translate in the same cycle sees the old entry
        @(negedge clk);
        wr_en = 1; wr_idx = 4'd4; wr_base = 32'h4400_0000; wr_size = 28'h10; wr_prot = 2'd1;
        va = 32'h4000_0008; acc = 2'd0;
        exp_q.push_back(model(32'h4000_0008, 2'd0));
        tag_q.push_back("R7 R10 old contents same cycle");
        sb[4] = 32'h4400_0000; ss[4] = 28'h10; sp[4] = 2'd1;
        @(negedge clk);
        wr_en = 0;
        xl(32'h4000_0008, 2'd0, "R7 new contents next cycle");
        xl(32'h1000_0010, 2'd0, "R7 neighbour unchanged");

        // R8: context image layout
        @(negedge clk);
        check(ctx_out == image(), "R8 context layout", ctx_out, image());
        saved = ctx_out;

        wr(4'd1, 32'h0, 28'h0, 2'd0);
        xl(32'h1000_0010, 2'd0, "R7 seg1 cleared");

        // R9: context load wins over a same-cycle single write
        @(negedge clk);
        ctx_in = saved; ctx_load = 1;
        wr_en = 1; wr_idx = 4'd1; wr_base = 32'hDEAD_0000; wr_size = 28'h1; wr_prot = 2'd2;
        sb[1] = 32'h1000_0000; ss[1] = 28'h0000FFF; sp[1] = 2'd1;
        @(negedge clk);
        ctx_load = 0; wr_en = 0;
        check(ctx_out == saved, "R9 table restored", ctx_out, saved);
        xl(32'h1000_0010, 2'd0, "R9 seg1 restored over write");
        xl(32'h2000_0010, 2'd1, "R9 seg2 restored");

        // R6: reset again clears the table
        @(negedge clk);
        rst_n = 0;
        for (int i = 0; i < NS; i++) begin sb[i] = '0; ss[i] = '0; sp[i] = '0; end
        @(negedge clk);
        rst_n = 1;
        check(ctx_out == '0, "R6 reset clears loaded table", ctx_out, '0);
        xl(32'h1000_0010, 2'd0, "R6 seg1 faults after reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule